// File: doc/BRIEF.md
# Memory Access Protection Checker

This block screens one memory access per request before it reaches the memory system. The requester presents a 32-bit address, an access width, the kind of access (data read, data write or instruction fetch), a selector for one of three core variants, a RAM-enable control bit and an alignment-exception mask bit. One clock later the block returns the address to use, which may have had its low bits forced to zero, together with four fault flags: misaligned, access error, access exception and store error.

Data accesses pass through two stages in series. The first applies a rule set picked by the variant and the access kind. The second applies a region check shared by reads and writes. The second stage sees the address that the first stage produced. Instruction fetches use a single fetch rule set per variant. The four flags are independent bits, so one access can raise more than one of them. A variant or kind code that is not in use passes the address through unchanged and raises no flag.

Top module: `mem_access_guard`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `out_valid` and all four fault flags are 0.
- R2: A request on `in_valid` produces `out_valid` exactly one cycle later. When `in_valid` is low, the following cycle has `out_valid` low and all flags 0.
- R3: `size_code` 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 also select 16 bytes. The alignment mask is the byte count minus 1. `kind` 0 is a read, 1 a write and 2 a fetch. `variant` 0, 1 and 2 select variants A, B and C.
- R4: Variant A, data stage one: an access with mask exactly 7 and an address in 0xFE800000–0xFEFFFFFF raises the access error on a read and the store error on a write.
- R5: Variant A, shared stage: an address with any mask bit set is realigned. It raises the access error only when `align_exc_mask` is 0.
- R6: Variant B, data: an address with any mask bit set raises misaligned and is realigned. Then a realigned address in 0xFE800000–0xFEFEFFFF or 0xFEFF0600–0xFEFF7FFF raises the access error on a read and the store error on a write.
- R7: Variant B, shared stage: an address in 0xFE000000–0xFE7FFFFF raises the access exception.
- R8: Variant C, data stage one: 0xFE800000–0xFEFEFFFF always faults. 0xFEFF0000–0xFEFFFFFF faults only when the mask exceeds 3. A fault is the access error on a read and the store error on a write.
- R9: Variant C, shared stage: 0xFE000000–0xFE3FFFFF and 0xFE408000–0xFE7FFFFF raise the access exception. 0xFE400000–0xFE407FFF raises it only when `ram_en` is 0. Data addresses on variant C are never realigned.
- R10: Variant A, fetch: a misaligned address is realigned and raises the access error. An aligned address in 0xFE800000–0xFEFFFFFF also raises the access error.
- R11: Variant B, fetch: misalignment is flagged and realigned. The error windows of R6 raise the access error. Otherwise 0xFE004000–0xFE7FFFFF raises the exception. Otherwise 0xFE000000–0xFE003FFF raises the exception when `ram_en` is 0.
- R12: Variant C, fetch: the address is always realigned and misaligned is never raised. 0xFE800000–0xFEFFFFFF raises the access error. Otherwise 0xFE008000–0xFE7FFFFF raises the exception. Otherwise 0xFE000000–0xFE007FFF raises the exception when `ram_en` is 0.
- R13: A `variant` code of 3 or a `kind` code of 3 returns the address unchanged with every flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| addr | input | 32 | Requested address |
| size_code | input | 3 | Access width code (R3) |
| kind | input | 2 | 0 read, 1 write, 2 fetch, 3 none |
| variant | input | 2 | 0 A, 1 B, 2 C, 3 none |
| ram_en | input | 1 | RAM-enable control bit |
| align_exc_mask | input | 1 | Suppresses the variant A alignment error |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_addr | output | 32 | Corrected address |
| flt_misalign | output | 1 | Misaligned fault |
| flt_acc_err | output | 1 | Access error |
| flt_acc_exc | output | 1 | Access exception |
| flt_store_err | output | 1 | Store error |

## Verification
The hardest cases to reach are the ones that depend on an exact boundary: the first or last byte of a window, combined with one particular width, for example the 0xFEFF0000 window that faults only above a 4-byte mask, or the RAM-gated windows whose result flips with `ram_en`. Uniformly random 32-bit addresses almost never land on these bytes. The stimulus therefore sweeps every window edge and its neighbour byte across all variants, kinds, widths and control-bit settings. It then adds random traffic biased towards the 0xFE high byte, with small offsets that make the address misaligned.

// File: rtl/mag_pkg.sv
// Shared types and helpers for the memory access protection checker.
// Assumes a 32-bit address space; window bounds are fixed constants.
package mag_pkg;
    localparam int ADDR_W   = 32;
    localparam int SIZE_W   = 3;
    localparam int MAX_LOG2 = 4;   // largest access is 2**MAX_LOG2 bytes

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_NONE  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        VAR_A    = 2'd0,
        VAR_B    = 2'd1,
        VAR_C    = 2'd2,
        VAR_NONE = 2'd3
    } variant_e;

    typedef struct packed {
        logic misalign;
        logic acc_err;
        logic acc_exc;
        logic store_err;
    } fault_t;

    // Inclusive window membership test.
    function automatic logic in_win(input addr_t a, input addr_t lo, input addr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

    // Size code to alignment mask; codes past MAX_LOG2 saturate.
    function automatic addr_t size_to_mask(input logic [SIZE_W-1:0] code);
        addr_t m;
        if (int'(code) >= MAX_LOG2) m = addr_t'((1 << MAX_LOG2) - 1);
        else                        m = addr_t'((1 << code) - 1);
        return m;
    endfunction
endpackage

// File: rtl/mag_kind_check.sv
// First stage: rules chosen by access kind and core variant.
// Purely combinational. May realign the address; the result feeds the
// shared region stage for data accesses. Fetches finish here.
module mag_kind_check
    import mag_pkg::*;
(
    input  addr_t    addr_i,
    input  addr_t    mask_i,
    input  kind_e    kind_i,
    input  variant_e variant_i,
    input  logic     ram_en_i,
    output addr_t    addr_o,
    output fault_t   flt_o
);
    logic is_data;
    logic is_write;
    logic mis;
    addr_t aligned;

    assign is_data  = (kind_i == KIND_READ) || (kind_i == KIND_WRITE);
    assign is_write = (kind_i == KIND_WRITE);
    assign mis      = |(addr_i & mask_i);
    assign aligned  = addr_i & ~mask_i;

    // Per-variant rule evaluation.
    always_comb begin
        logic hit;
        addr_o = addr_i;
        flt_o  = '0;
        hit    = 1'b0;
        unique case (variant_i)
            VAR_A: begin
                if (kind_i == KIND_FETCH) begin
                    if (mis) begin
                        flt_o.acc_err = 1'b1;
                        addr_o        = aligned;
                    end else if (in_win(addr_i, 32'hFE80_0000, 32'hFEFF_FFFF)) begin
                        flt_o.acc_err = 1'b1;
                    end
                end else if (is_data) begin
                    hit = (mask_i == addr_t'(7)) &&
                          in_win(addr_i, 32'hFE80_0000, 32'hFEFF_FFFF);
                end
            end
            VAR_B: begin
                if (kind_i != KIND_NONE) begin
                    flt_o.misalign = mis;
                    addr_o         = aligned;
                    hit = in_win(aligned, 32'hFE80_0000, 32'hFEFE_FFFF) ||
                          in_win(aligned, 32'hFEFF_0600, 32'hFEFF_7FFF);
                    if (kind_i == KIND_FETCH) begin
                        if (hit)
                            flt_o.acc_err = 1'b1;
                        else if (in_win(aligned, 32'hFE00_4000, 32'hFE7F_FFFF))
                            flt_o.acc_exc = 1'b1;
                        else if (!ram_en_i && in_win(aligned, 32'hFE00_0000, 32'hFE00_3FFF))
                            flt_o.acc_exc = 1'b1;
                        hit = 1'b0;
                    end
                end
            end
            VAR_C: begin
                if (kind_i == KIND_FETCH) begin
                    addr_o = aligned;
                    if (in_win(aligned, 32'hFE80_0000, 32'hFEFF_FFFF))
                        flt_o.acc_err = 1'b1;
                    else if (in_win(aligned, 32'hFE00_8000, 32'hFE7F_FFFF))
                        flt_o.acc_exc = 1'b1;
                    else if (!ram_en_i && in_win(aligned, 32'hFE00_0000, 32'hFE00_7FFF))
                        flt_o.acc_exc = 1'b1;
                end else if (is_data) begin
                    hit = in_win(addr_i, 32'hFE80_0000, 32'hFEFE_FFFF) ||
                          ((mask_i > addr_t'(3)) &&
                           in_win(addr_i, 32'hFEFF_0000, 32'hFEFF_FFFF));
                end
            end
            default: ;
        endcase
        if (is_data && hit) begin
            if (is_write) flt_o.store_err = 1'b1;
            else          flt_o.acc_err   = 1'b1;
        end
    end
endmodule

// File: rtl/mag_region_check.sv
// Second stage: region check shared by data reads and writes.
// Combinational; disabled (pass-through, no flags) when en_i is low.
module mag_region_check
    import mag_pkg::*;
(
    input  logic     en_i,
    input  addr_t    addr_i,
    input  addr_t    mask_i,
    input  variant_e variant_i,
    input  logic     ram_en_i,
    input  logic     align_exc_mask_i,
    output addr_t    addr_o,
    output fault_t   flt_o
);
    // Per-variant shared region rules.
    always_comb begin
        addr_o = addr_i;
        flt_o  = '0;
        if (en_i) begin
            unique case (variant_i)
                VAR_A: begin
                    if (|(addr_i & mask_i)) begin
                        flt_o.acc_err = !align_exc_mask_i;
                        addr_o        = addr_i & ~mask_i;
                    end
                end
                VAR_B: begin
                    flt_o.acc_exc = in_win(addr_i, 32'hFE00_0000, 32'hFE7F_FFFF);
                end
                VAR_C: begin
                    if (in_win(addr_i, 32'hFE00_0000, 32'hFE3F_FFFF) ||
                        in_win(addr_i, 32'hFE40_8000, 32'hFE7F_FFFF))
                        flt_o.acc_exc = 1'b1;
                    else if (!ram_en_i && in_win(addr_i, 32'hFE40_0000, 32'hFE40_7FFF))
                        flt_o.acc_exc = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mem_access_guard.sv
// Top: chains the kind stage and shared region stage, then registers
// the corrected address and merged fault flags with a one-cycle strobe.
// Assumes inputs are stable around the clock edge; synchronous reset.
module mem_access_guard
    import mag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       addr,
    input  logic [2:0]        size_code,
    input  logic [1:0]        kind,
    input  logic [1:0]        variant,
    input  logic              ram_en,
    input  logic              align_exc_mask,
    output logic              out_valid,
    output logic [31:0]       out_addr,
    output logic              flt_misalign,
    output logic              flt_acc_err,
    output logic              flt_acc_exc,
    output logic              flt_store_err
);
    kind_e    kind_q;
    variant_e var_q;
    addr_t    mask;
    addr_t    stage1_addr;
    addr_t    stage2_addr;
    fault_t   stage1_flt;
    fault_t   stage2_flt;
    fault_t   merged;
    fault_t   flt_r;
    logic     shared_en;

    assign kind_q    = kind_e'(kind);
    assign var_q     = variant_e'(variant);
    assign mask      = size_to_mask(size_code);
    assign shared_en = (kind_q == KIND_READ) || (kind_q == KIND_WRITE);

    mag_kind_check u_kind (
        .addr_i    (addr),
        .mask_i    (mask),
        .kind_i    (kind_q),
        .variant_i (var_q),
        .ram_en_i  (ram_en),
        .addr_o    (stage1_addr),
        .flt_o     (stage1_flt)
    );

    mag_region_check u_region (
        .en_i             (shared_en),
        .addr_i           (stage1_addr),
        .mask_i           (mask),
        .variant_i        (var_q),
        .ram_en_i         (ram_en),
        .align_exc_mask_i (align_exc_mask),
        .addr_o           (stage2_addr),
        .flt_o            (stage2_flt)
    );

    assign merged = stage1_flt | stage2_flt;

    // Result register: strobe, address and flags for the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            flt_r     <= '0;
        end else begin
            out_valid <= in_valid;
            flt_r     <= in_valid ? merged : '0;
            if (in_valid) out_addr <= stage2_addr;
        end
    end

    assign flt_misalign  = flt_r.misalign;
    assign flt_acc_err   = flt_r.acc_err;
    assign flt_acc_exc   = flt_r.acc_exc;
    assign flt_store_err = flt_r.store_err;
endmodule

// File: rtl/mem_access_guard_chk.sv
// Property checker bound to mem_access_guard; observes ports only.
module mem_access_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] addr,
    input logic [2:0]  size_code,
    input logic [1:0]  kind,
    input logic [1:0]  variant,
    input logic        out_valid,
    input logic [31:0] out_addr,
    input logic        flt_misalign,
    input logic        flt_acc_err,
    input logic        flt_acc_exc,
    input logic        flt_store_err
);
    logic [3:0]  flags;
    logic [31:0] mask;
    assign flags = {flt_misalign, flt_acc_err, flt_acc_exc, flt_store_err};
    assign mask  = (size_code >= 3'd4) ? 32'd15 : ((32'd1 << size_code) - 32'd1);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && flags == 4'b0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> flags == 4'b0);

    a_r13_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (variant == 2'd3 || kind == 2'd3)) |=>
        (out_addr == $past(addr) && flags == 4'b0));

    a_r9_c_data_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && variant == 2'd2 && kind <= 2'd1) |=> out_addr == $past(addr));

    a_r6_b_realigned: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && variant == 2'd1 && kind != 2'd3) |=>
        ((out_addr & $past(mask)) == 32'd0 &&
         flt_misalign == |($past(addr) & $past(mask))));

    a_r4_store_only_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind != 2'd1) |=> !flt_store_err);
endmodule

bind mem_access_guard mem_access_guard_chk u_chk (.*);

// File: tb/sim_mem_access_guard.sv
// Bench: boundary sweep plus seeded random traffic against a model.
module sim_mem_access_guard;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] addr = '0;
    logic [2:0]  size_code = '0;
    logic [1:0]  kind = '0;
    logic [1:0]  variant = '0;
    logic        ram_en = 1'b0;
    logic        align_exc_mask = 1'b0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        flt_misalign, flt_acc_err, flt_acc_exc, flt_store_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_access_guard u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr),
        .size_code(size_code), .kind(kind), .variant(variant),
        .ram_en(ram_en), .align_exc_mask(align_exc_mask),
        .out_valid(out_valid), .out_addr(out_addr),
        .flt_misalign(flt_misalign), .flt_acc_err(flt_acc_err),
        .flt_acc_exc(flt_acc_exc), .flt_store_err(flt_store_err)
    );

    function automatic bit w(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
        return a >= lo && a <= hi;
    endfunction

    // Expected {addr, misalign, acc_err, acc_exc, store_err} from the requirements.
    function automatic logic [35:0] model(input logic [31:0] a, input logic [2:0] sc,
                                          input logic [1:0] k, input logic [1:0] v,
                                          input logic re, input logic aem);
        logic [31:0] m, x;
        bit mi, er, ex, st, f;
        m = (sc >= 3'd4) ? 32'd15 : ((32'd1 << sc) - 32'd1);
        x = a; mi = 0; er = 0; ex = 0; st = 0; f = 0;
        if (v == 2'd3 || k == 2'd3) return {a, 4'b0};
        if (k == 2'd2) begin
            if (v == 2'd0) begin
                if ((a & m) != 0) begin er = 1; x = a & ~m; end
                else if (w(a, 32'hFE800000, 32'hFEFFFFFF)) er = 1;
            end else if (v == 2'd1) begin
                mi = (a & m) != 0; x = a & ~m;
                if (w(x, 32'hFEFF0600, 32'hFEFF7FFF) || w(x, 32'hFE800000, 32'hFEFEFFFF)) er = 1;
                else if (w(x, 32'hFE004000, 32'hFE7FFFFF)) ex = 1;
                else if (!re && w(x, 32'hFE000000, 32'hFE003FFF)) ex = 1;
            end else begin
                x = a & ~m;
                if (w(x, 32'hFE800000, 32'hFEFFFFFF)) er = 1;
                else if (w(x, 32'hFE008000, 32'hFE7FFFFF)) ex = 1;
                else if (!re && w(x, 32'hFE000000, 32'hFE007FFF)) ex = 1;
            end
            return {x, mi, er, ex, st};
        end
        // data: stage one
        if (v == 2'd0) f = (m == 32'd7) && w(a, 32'hFE800000, 32'hFEFFFFFF);
        else if (v == 2'd1) begin
            mi = (a & m) != 0; x = a & ~m;
            f = w(x, 32'hFEFF0600, 32'hFEFF7FFF) || w(x, 32'hFE800000, 32'hFEFEFFFF);
        end else
            f = w(a, 32'hFE800000, 32'hFEFEFFFF) || (m > 3 && w(a, 32'hFEFF0000, 32'hFEFFFFFF));
        if (f) begin if (k == 2'd1) st = 1; else er = 1; end
        // data: shared stage
        if (v == 2'd0) begin
            if ((x & m) != 0) begin if (!aem) er = 1; x = x & ~m; end
        end else if (v == 2'd1) begin
            if (w(x, 32'hFE000000, 32'hFE7FFFFF)) ex = 1;
        end else begin
            if (w(x, 32'hFE000000, 32'hFE3FFFFF) || w(x, 32'hFE408000, 32'hFE7FFFFF)) ex = 1;
            else if (!re && w(x, 32'hFE400000, 32'hFE407FFF)) ex = 1;
        end
        return {x, mi, er, ex, st};
    endfunction

    function automatic string tag(input logic [1:0] k, input logic [1:0] v);
        if (v == 2'd3 || k == 2'd3) return "R13";
        if (k == 2'd2) return (v == 2'd0) ? "R10" : (v == 2'd1) ? "R11" : "R12";
        return (v == 2'd0) ? "R4/R5" : (v == 2'd1) ? "R6/R7" : "R8/R9";
    endfunction

    function automatic logic [31:0] edge_addr(input int i);
        case (i)
            0: return 32'hFE000000;  1: return 32'hFE003FFF;  2: return 32'hFE004000;
            3: return 32'hFE007FFF;  4: return 32'hFE008000;  5: return 32'hFE3FFFFF;
            6: return 32'hFE400000;  7: return 32'hFE407FFF;  8: return 32'hFE408000;
            9: return 32'hFE7FFFFF; 10: return 32'hFE800000; 11: return 32'hFEFEFFFF;
           12: return 32'hFEFF0000; 13: return 32'hFEFF05FF; 14: return 32'hFEFF0600;
           15: return 32'hFEFF7FFF; 16: return 32'hFEFF8000; 17: return 32'hFEFFFFFF;
           18: return 32'hFF000000; default: return 32'hFDFFFFFF;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Drive one request at a falling edge, check it at the next falling edge.
    task automatic apply(input logic [31:0] a, input logic [2:0] sc, input logic [1:0] k,
                         input logic [1:0] v, input logic re, input logic aem);
        logic [35:0] exp, got;
        addr = a; size_code = sc; kind = k; variant = v;
        ram_en = re; align_exc_mask = aem; in_valid = 1'b1;
        exp = model(a, sc, k, v, re, aem);
        @(negedge clk);
        got = {out_addr, flt_misalign, flt_acc_err, flt_acc_exc, flt_store_err};
        n_checks++;
        if (!out_valid || got !== exp) begin
            n_fail++;
            $display("FAIL %s (R2/R3) a=%h sc=%0d k=%0d v=%0d re=%0b aem=%0b: got v=%0b %h expected %h",
                     tag(k, v), a, sc, k, v, re, aem, out_valid, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1: outputs held low during reset with a request pending
        in_valid = 1'b1; addr = 32'hFE800001; size_code = 3'd3;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid || flt_misalign || flt_acc_err || flt_acc_exc || flt_store_err) begin
            n_fail++;
            $display("FAIL R1 reset state: got v=%0b flags=%b expected 0 0000", out_valid,
                     {flt_misalign, flt_acc_err, flt_acc_exc, flt_store_err});
        end
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid) begin
            n_fail++; $display("FAIL R1 after reset: got out_valid=1 expected 0");
        end
        // Boundary sweep over edges and neighbours, all variants/kinds/sizes/controls.
        for (int e = 0; e < 20; e++)
            for (int d = 0; d < 2; d++)
                for (int v = 0; v < 4; v++)
                    for (int k = 0; k < 4; k++)
                        for (int s = 0; s < 6; s++)
                            for (int c = 0; c < 4; c++)
                                if (!(d == 1 && (v == 3 || k == 3)))
                                    apply(edge_addr(e) + 32'(d * ((s % 3) + 1)), 3'(s),
                                          2'(k), 2'(v), c[0], c[1]);
        // R2: idle cycle gives no strobe and no flags
        in_valid = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid || flt_misalign || flt_acc_err || flt_acc_exc || flt_store_err) begin
            n_fail++;
            $display("FAIL R2 idle: got v=%0b flags=%b expected 0 0000", out_valid,
                     {flt_misalign, flt_acc_err, flt_acc_exc, flt_store_err});
        end
        // Random traffic biased to the 0xFE page with small misaligning offsets.
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [31:0] a;
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 5)      a = {8'hFE, 24'($urandom)};
            else if (sel < 9) a = edge_addr(int'($urandom_range(0, 19))) + 32'($urandom_range(0, 15));
            else              a = $urandom;
            apply(a, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                  2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
        end
        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule